// File: doc/BRIEF.md
# SMBus Target with Power-On Address Capture

This block is the target side of an SMBus serial link. It cleans up the clock and data lines, detects START and STOP conditions, and shifts in a 7-bit address and a direction bit. It acknowledges its own address, and a write or read transaction then accesses a small bank of byte registers. In a write, the first data byte sets a register pointer. Each later byte goes to the register at the pointer. A read returns bytes starting at the pointer. The pointer steps forward after every byte in both directions.

The upper five address bits are hard-wired. The lowest two bits come from a board-level select input, which arrives already decoded as a 2-bit code. The block copies those two bits once, on the first transaction whose upper five address bits match. It keeps them frozen until the next reset, even if the select input changes later. The data line is driven open-drain: the block only ever pulls it low.

Top module: `smbus_target`

## Requirements
- R1: The target address is 01011 followed by two low bits taken from `sel_code`: code 00 gives 00, 01 gives 01, 10 gives 10, and 11 gives 00. Only a byte whose top seven bits equal this address is acknowledged.
- R2: The low address bits are captured on the first address byte after reset whose top five bits are 01011, whether or not its low bits match. From then on they ignore `sel_code` until reset.
- R3: START is data falling while the clock is high. STOP is data rising while the clock is high. STOP returns the block to idle with the data line released. A START seen at any point, including in the middle of a transfer, begins a new address phase.
- R4: The address byte arrives MSB first, with bit 0 as the direction bit (0 = write, 1 = read). On a match, the block pulls the data line low for the whole ninth clock.
- R5: After a non-matching address, the block gives no acknowledge and does not drive the data line for any later clock until the next START.
- R6: In a write, the first byte after the address loads the register pointer from its low bits. Each later byte is stored at the pointer, and the pointer then advances, wrapping modulo NREG. Every written byte is acknowledged.
- R7: In a read, the block sends the register at the pointer MSB first and then advances the pointer. After a master acknowledge it sends the next register. After a master not-acknowledge it stops driving.
- R8: The block begins pulling the data line low only while the filtered clock is low.
- R9: A level change on either line that lasts fewer than FILT_LEN system clocks has no effect on the transfer.
- R10: After reset the data line is released, every register reads 0, and no address is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sel_code | input | 2 | Decoded address-select level |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
The first address is sent with low bits that do not match the select code, and then with the select code changed. This shows that capture happens on the first upper-five match and that the captured bits ignore later select changes. A foreign address is followed by extra clocked bytes, which separates "no acknowledge" from "never drives again before START". Writes that cross the last register, a repeated START into a read, and a read that ends on a master not-acknowledge exercise pointer wrap and read termination. A write byte with short pulses on both lines shows whether the filter rejects glitches: a passed clock glitch would add a bit, and a passed data glitch would form a false START.

// File: rtl/smb_pkg.sv
package smb_pkg;
    localparam logic [4:0] ADDR_HI = 5'b01011;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK
    } smb_state_e;

    function automatic logic [1:0] sel_to_low(input logic [1:0] code);
        return (code == 2'b11) ? 2'b00 : code;
    endfunction
endpackage

// File: rtl/smb_filter.sv
module smb_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sy_d, sy_q;
    logic [CW-1:0]          cnt_d, cnt_q;
    logic                   lvl_d, lvl_q;

    always_comb begin
        sy_d  = {sy_q[SYNC_STAGES-2:0], d_i};
        cnt_d = '0;
        lvl_d = lvl_q;
        if (sy_q[SYNC_STAGES-1] != lvl_q) begin
            if (cnt_q == CW'(FILT_LEN - 1)) begin
                lvl_d = sy_q[SYNC_STAGES-1];
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q  <= '1;
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else begin
            sy_q  <= sy_d;
            cnt_q <= cnt_d;
            lvl_q <= lvl_d;
        end
    end

    assign q_o = lvl_q;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile #(
    parameter int NREG  = 8,
    parameter int PTR_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [PTR_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= 8'h00;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/smbus_target.sv
module smbus_target #(
    parameter int NREG        = 8,
    parameter int FILT_LEN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] sel_code,
    output logic       sda_oe
);
    import smb_pkg::*;

    localparam int PTR_W = $clog2(NREG);
    localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

    typedef struct packed {
        smb_state_e       st;
        logic             prev_scl;
        logic             prev_sda;
        logic [3:0]       cnt;
        logic [7:0]       sh;
        logic             rw;
        logic             first;
        logic             mack;
        logic [PTR_W-1:0] ptr;
        logic             locked;
        logic [1:0]       low;
        logic             oe;
    } ctl_t;

    ctl_t q, d;

    logic [1:0] raw, filt;
    logic       scl_f, sda_f;
    logic       we;
    logic [7:0] rdata;
    logic       lock_q;
    logic [1:0] low_q;

    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        smb_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .d_i(raw[g]), .q_o(filt[g])
        );
    end

    assign scl_f = filt[0];
    assign sda_f = filt[1];

    smb_regfile #(.NREG(NREG), .PTR_W(PTR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(q.ptr),
        .wdata(q.sh), .raddr(q.ptr), .rdata(rdata)
    );

    logic       scl_rise, scl_fall, start_c, stop_c;
    logic [1:0] low_v;

    always_comb begin
        scl_rise = scl_f & ~q.prev_scl;
        scl_fall = ~scl_f & q.prev_scl;
        start_c  = scl_f & q.prev_scl & ~sda_f & q.prev_sda;
        stop_c   = scl_f & q.prev_scl & sda_f & ~q.prev_sda;
        low_v    = q.locked ? q.low : sel_to_low(sel_code);

        d          = q;
        we         = 1'b0;
        d.prev_scl = scl_f;
        d.prev_sda = sda_f;

        if (stop_c) begin
            d.st = S_IDLE;
            d.oe = 1'b0;
        end else if (start_c) begin
            d.st    = S_ADDR;
            d.cnt   = '0;
            d.first = 1'b1;
            d.oe    = 1'b0;
        end else begin
            unique case (q.st)
                S_ADDR, S_WR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_f};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        if (q.st == S_ADDR) begin
                            if (q.sh[7:3] == ADDR_HI) begin
                                d.locked = 1'b1;
                                d.low    = low_v;
                            end
                            if (q.sh[7:3] == ADDR_HI && q.sh[2:1] == low_v) begin
                                d.oe = 1'b1;
                                d.rw = q.sh[0];
                                d.st = S_ADDR_ACK;
                            end else begin
                                d.st = S_IDLE;
                            end
                        end else begin
                            d.oe = 1'b1;
                            d.st = S_WR_ACK;
                            if (q.first) begin
                                d.ptr   = q.sh[PTR_W-1:0];
                                d.first = 1'b0;
                            end else begin
                                we    = 1'b1;
                                d.ptr = q.ptr + PTR_ONE;
                            end
                        end
                    end
                end
                S_ADDR_ACK, S_WR_ACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.st == S_ADDR_ACK && q.rw) begin
                            d.sh = rdata;
                            d.oe = ~rdata[7];
                            d.st = S_RD;
                        end else begin
                            d.oe = 1'b0;
                            d.st = S_WR;
                        end
                    end
                end
                S_RD: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe  = 1'b0;
                            d.ptr = q.ptr + PTR_ONE;
                            d.st  = S_RD_ACK;
                        end else begin
                            d.sh = {q.sh[6:0], 1'b0};
                            d.oe = ~q.sh[6];
                        end
                    end
                end
                S_RD_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_f;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.sh  = rdata;
                            d.oe  = ~rdata[7];
                            d.cnt = '0;
                            d.st  = S_RD;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                default: d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= S_IDLE;
            q.prev_scl <= 1'b1;
            q.prev_sda <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign lock_q = q.locked;
    assign low_q  = q.low;
endmodule

// File: rtl/smb_chk.sv
module smb_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       sda_f,
    input logic       sda_oe,
    input logic       lock_q,
    input logic [1:0] low_q
);
    // R2: once captured, the address stays captured
    a_r2_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R2: captured low bits never move afterwards
    a_r2_low_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(low_q));

    // R3: a STOP on the filtered lines leaves the data line released
    a_r3_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && sda_f && !$past(sda_f)) |=> !sda_oe);

    // R8: pulling low starts only while the clock is low
    a_r8_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f);
endmodule

bind smbus_target smb_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
    .sda_oe(sda_oe), .lock_q(lock_q), .low_q(low_q)
);

// File: tb/sim_smbus_target.sv
module sim_smbus_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] sel_code = 2'b01;
    logic       sda_oe;
    logic       sda_w;

    assign sda_w = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_w),
        .sel_code(sel_code), .sda_oe(sda_oe)
    );

    int total = 0;
    int bad = 0;

    typedef struct { string tag; int val; } item_t;
    item_t exp_q[$];
    int    act_q[$];
    event  got;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(got);
            while (act_q.size() > 0) begin
                item_t e;
                int a;
                a = act_q.pop_front();
                if (exp_q.size() == 0) chk("scoreboard-underflow", a, -1);
                else begin
                    e = exp_q.pop_front();
                    chk(e.tag, a, e.val);
                end
            end
        end
    end

    task automatic waitq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        sda_m = 1'b1; waitq(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    waitq(Q);
        scl_m = 1'b1; waitq(2*Q);
        scl_m = 1'b0; waitq(Q);
    endtask

    task automatic send(input logic [7:0] b, input int exp_ack, input string tag,
                        input bit glitch);
        logic ack;
        exp_q.push_back('{tag, exp_ack});
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; waitq(Q);
            scl_m = 1'b1; waitq(Q/2);
            if (glitch && i == 4) begin
                scl_m = 1'b0; waitq(2); scl_m = 1'b1;
            end
            if (glitch && i == 2) begin
                sda_m = ~sda_m; waitq(2); sda_m = ~sda_m;
            end
            waitq(Q + Q/2 - ((glitch && (i == 4 || i == 2)) ? 2 : 0));
            scl_m = 1'b0; waitq(Q);
        end
        sda_m = 1'b1; waitq(Q);
        scl_m = 1'b1; waitq(Q);
        ack = ~sda_w; waitq(Q);
        scl_m = 1'b0; waitq(Q);
        act_q.push_back(int'(ack)); ->got;
    endtask

    task automatic recv(input logic [7:0] exp_v, input bit mack, input string tag);
        logic [7:0] v = 8'h00;
        exp_q.push_back('{tag, int'(exp_v)});
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; waitq(Q);
            scl_m = 1'b1; waitq(Q);
            v = {v[6:0], sda_w}; waitq(Q);
            scl_m = 1'b0; waitq(Q);
        end
        put_bit(~mack);
        act_q.push_back(int'(v)); ->got;
    endtask

    task automatic do_reset(input logic [1:0] sel);
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; sel_code = sel;
        waitq(5);
        rst_n = 1'b1;
        waitq(10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset(2'b01);
        chk("R10 sda_oe after reset", int'(sda_oe), 0);

        // R2: first upper-five match captures 01; low bits 10 do not match
        do_start(); send({7'b0101110, 1'b0}, 0, "R2 first match captures sel, mismatched low bits nack", 0); do_stop();
        sel_code = 2'b10;
        do_start(); send({7'b0101110, 1'b0}, 0, "R2 later sel change ignored", 0); do_stop();
        // R1/R6: write registers 3,4
        do_start();
        send({7'b0101101, 1'b0}, 1, "R1 R4 captured address acked", 0);
        send(8'h03, 1, "R6 command byte acked", 0);
        send(8'hA5, 1, "R6 data byte acked", 0);
        send(8'h3C, 1, "R6 second data byte acked", 0);
        do_stop();
        chk("R3 released after STOP", int'(sda_oe), 0);

        // R5: foreign address, then more clocked bytes
        do_start();
        send({7'b0110000, 1'b0}, 0, "R5 foreign address nack", 0);
        send(8'h00, 0, "R5 no drive on later byte", 0);
        send(8'h5A, 0, "R5 still no drive", 0);
        chk("R5 sda_oe low before next START", int'(sda_oe), 0);
        do_stop();

        // R7/R3: repeated START into read, auto-increment, master nack
        do_start();
        send({7'b0101101, 1'b0}, 1, "R6 address for pointer set", 0);
        send(8'h03, 1, "R6 pointer to 3", 0);
        do_start();
        send({7'b0101101, 1'b1}, 1, "R3 repeated START read address acked", 0);
        recv(8'hA5, 1, "R7 read reg3");
        recv(8'h3C, 1, "R7 read reg4 after increment");
        recv(8'h00, 0, "R7 read reg5 then nack");
        chk("R7 released after master nack", int'(sda_oe), 0);
        do_stop();

        // R6: wrap past last register
        do_start();
        send({7'b0101101, 1'b0}, 1, "R6 wrap addr", 0);
        send(8'h07, 1, "R6 pointer 7", 0);
        send(8'h11, 1, "R6 write reg7", 0);
        send(8'h22, 1, "R6 write wraps to reg0", 0);
        do_stop();
        do_start();
        send({7'b0101101, 1'b0}, 1, "R6 wrap readback addr", 0);
        send(8'h07, 1, "R6 wrap readback ptr", 0);
        do_start();
        send({7'b0101101, 1'b1}, 1, "R7 read address", 0);
        recv(8'h11, 1, "R6 reg7 holds first byte");
        recv(8'h22, 0, "R6 reg0 holds wrapped byte");
        do_stop();

        // R9: short pulses on both lines during a written byte
        do_start();
        send({7'b0101101, 1'b0}, 1, "R9 addr", 0);
        send(8'h02, 1, "R9 pointer 2", 0);
        send(8'h96, 1, "R9 glitched byte acked", 1);
        do_stop();
        do_start();
        send({7'b0101101, 1'b0}, 1, "R9 readback addr", 0);
        send(8'h02, 1, "R9 readback ptr", 0);
        do_start();
        send({7'b0101101, 1'b1}, 1, "R9 read addr", 0);
        recv(8'h96, 0, "R9 glitches rejected");
        do_stop();

        // R10/R1: reset clears registers and capture; code 10 -> low bits 10
        do_reset(2'b10);
        chk("R10 sda_oe after second reset", int'(sda_oe), 0);
        do_start();
        send({7'b0101110, 1'b0}, 1, "R1 code 10 gives 0101110", 0);
        send(8'h03, 1, "R10 pointer 3", 0);
        do_start();
        send({7'b0101110, 1'b1}, 1, "R10 read addr", 0);
        recv(8'h00, 0, "R10 registers cleared by reset");
        do_stop();

        // R1: code 11 maps to low bits 00
        do_reset(2'b11);
        do_start(); send({7'b0101100, 1'b0}, 1, "R1 code 11 gives 0101100", 0); do_stop();

        waitq(4);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule